// File: doc/BRIEF.md
# GPIO port register interface

This block is the software-visible register file of one general-purpose I/O port with a parameterised pin count (sixteen by default). A simple word-wide bus reaches it with an address, a write enable, write data, a read enable and registered read data. The registers hold the following per-pin settings:

- pin direction mode
- output driver type
- slew setting
- pull selection
- output levels
- a lock word
- two alternate-function words
- an analog-switch word

The lock, alternate-function and analog words are plain storage. The direction mode, driver type, slew, pull and output-level settings leave the block as configuration vectors that feed the pin-resolution logic.

Software changes output levels atomically in two ways, without a read-modify-write:

- **Set/clear register.** Its upper half clears output bits and its lower half sets them. Where one pin is named in both halves, the set wins.
- **Clear-only register.** Its lower half clears output bits.

The resolved pin levels enter the block on `pin_level` and read back through the input word, which is read-only.

Two one-cycle strobes tell the neighbouring logic when to work again:

- A write to the mode or driver-type word fires `contention_stb`, so that driver contention is checked again.
- A write to the pull, output, set/clear or clear-only word fires `resolve_stb`, so that input levels are resolved again.

The bus has no back-pressure. Every access completes in one cycle. Read data and the error flag appear in the cycle after the access.

Top module: `gpio_port_regs`

## Requirements
- R1: Word offsets are: mode 0x00, driver type 0x04, slew 0x08, pull 0x0C, input 0x10, output 0x14, set/clear 0x18, lock 0x1C, alt-low 0x20, alt-high 0x24, clear-only 0x28, analog 0x2C. After reset, mode, slew and pull hold their reset parameters and every other register holds zero.
- R2: A write sampled at a clock edge is visible on the configuration outputs after that edge. A register that is not written keeps its value.
- R3: A set/clear write clears the output bits that are one in bits [2P-1:P] and sets the output bits that are one in bits [P-1:0]. When a pin is named in both halves, it ends up set.
- R4: A clear-only write clears the output bits that are one in bits [P-1:0] and ignores bits [2P-1:P].
- R5: Reads of the set/clear and clear-only words return zero.
- R6: A read of the input word returns `pin_level` as sampled at the read edge, zero-extended. Writes to the input word change nothing.
- R7: The driver-type, output, lock and analog words store only bits [P-1:0], and their upper bits read as zero.
- R8: An access to an offset outside the map, or to an address whose two low bits are not zero, raises `bus_err` for one cycle. A read of such an address returns zero, and a write to it changes no register.
- R9: `contention_stb` is high for exactly the cycle after a write to the mode or driver-type word.
- R10: `resolve_stb` is high for exactly the cycle after a write to the pull, output, set/clear or clear-only word.
- R11: `mode_cfg`, `otype_cfg`, `slew_cfg`, `pull_cfg` and `out_level` always equal the stored register contents.
- R12: Read data is registered. It is valid in the cycle after the edge at which `bus_re` was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address inside the window |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 2*PINS | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 2*PINS | Registered read data |
| bus_err | output | 1 | One-cycle flag for an unmapped or misaligned access |
| pin_level | input | PINS | Resolved pin levels, read through the input word |
| mode_cfg | output | 2*PINS | Pin direction modes, two bits per pin |
| otype_cfg | output | PINS | Output driver type per pin |
| slew_cfg | output | 2*PINS | Slew settings, two bits per pin |
| pull_cfg | output | 2*PINS | Pull selections, two bits per pin |
| out_level | output | PINS | Output data levels |
| contention_stb | output | 1 | Pulse after a mode or driver-type write |
| resolve_stb | output | 1 | Pulse after a write that affects input resolution |

## Verification
The table first reads every reset value. It then drives the output word with a pattern whose upper half is all ones, which shows whether truncation to P bits takes place. Set/clear words are chosen so that one pin is named in both halves while other pins appear in only one, which separates set-wins behaviour from clear-wins and from plain overwrite. A clear-only write carries ones in its ignored upper half, so a design that decodes that half is exposed. The input word is read under two different pin patterns, with a write between the reads. Directed cases then time the two strobes and the error flag against an idle cycle, and use a misaligned write to show that no register changes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned NREGS = 12;

  typedef enum logic [3:0] {
    RI_MODE   = 4'd0,
    RI_OTYPE  = 4'd1,
    RI_SLEW   = 4'd2,
    RI_PULL   = 4'd3,
    RI_PIN_IN = 4'd4,
    RI_OUT    = 4'd5,
    RI_SETCLR = 4'd6,
    RI_LOCK   = 4'd7,
    RI_ALT_LO = 4'd8,
    RI_ALT_HI = 4'd9,
    RI_CLR    = 4'd10,
    RI_ANALOG = 4'd11
  } reg_idx_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode #(
  parameter int unsigned AW    = 10,
  parameter int unsigned NREGS = 12
) (
  input  logic [AW-1:0]    addr,
  output logic [NREGS-1:0] sel,
  output logic             hit
);
  localparam int unsigned IW = AW - 2;

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar i = 0; i < NREGS; i++) begin : g_sel
    assign sel[i] = aligned && (addr[AW-1:2] == IW'(i));
  end

  assign hit = |sel;
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_direct,
  input  logic              wr_setclr,
  input  logic              wr_clr,
  input  logic [2*PINS-1:0] wdata,
  output logic [PINS-1:0]   level
);
  logic [PINS-1:0] set_m, clr_m, nxt;

  assign set_m = wdata[PINS-1:0];
  assign clr_m = wdata[2*PINS-1:PINS];

  always_comb begin
    nxt = level;
    if (wr_direct)      nxt = set_m;
    else if (wr_setclr) nxt = (level & ~clr_m) | set_m;
    else if (wr_clr)    nxt = level & ~set_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= nxt;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setclr |=> ((level & $past(set_m)) == $past(set_m))); // R3
  AST_CLR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setclr |=> ((level & $past(clr_m) & ~$past(set_m)) == '0)); // R3
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((level & $past(set_m)) == '0)); // R4
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 12
) (
  input  logic [N-1:0]        sel,
  input  logic [N-1:0][W-1:0] words,
  output logic [W-1:0]        rd
);
  always_comb begin
    rd = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) rd = rd | words[i];
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned       PINS      = 16,
  parameter int unsigned       AW        = 10,
  parameter logic [2*PINS-1:0] MODE_RST  = '0,
  parameter logic [2*PINS-1:0] SLEW_RST  = '0,
  parameter logic [2*PINS-1:0] PULL_RST  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [2*PINS-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [2*PINS-1:0] bus_rdata,
  output logic              bus_err,
  input  logic [PINS-1:0]   pin_level,
  output logic [2*PINS-1:0] mode_cfg,
  output logic [PINS-1:0]   otype_cfg,
  output logic [2*PINS-1:0] slew_cfg,
  output logic [2*PINS-1:0] pull_cfg,
  output logic [PINS-1:0]   out_level,
  output logic              contention_stb,
  output logic              resolve_stb
);
  localparam int unsigned W = 2 * PINS;

  logic [NREGS-1:0]        sel;
  logic                    hit;
  logic [NREGS-1:0]        wr;
  logic [PINS-1:0]         lock_q, analog_q;
  logic [W-1:0]            alt_lo_q, alt_hi_q;
  logic [NREGS-1:0][W-1:0] words;
  logic [W-1:0]            rd_nxt;

  gpio_addr_decode #(.AW(AW), .NREGS(NREGS)) u_dec (
    .addr(bus_addr), .sel(sel), .hit(hit)
  );

  assign wr = sel & {NREGS{bus_we}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cfg  <= MODE_RST;
      slew_cfg  <= SLEW_RST;
      pull_cfg  <= PULL_RST;
      otype_cfg <= '0;
      lock_q    <= '0;
      analog_q  <= '0;
      alt_lo_q  <= '0;
      alt_hi_q  <= '0;
    end else begin
      if (wr[RI_MODE])   mode_cfg  <= bus_wdata;
      if (wr[RI_SLEW])   slew_cfg  <= bus_wdata;
      if (wr[RI_PULL])   pull_cfg  <= bus_wdata;
      if (wr[RI_OTYPE])  otype_cfg <= bus_wdata[PINS-1:0];
      if (wr[RI_LOCK])   lock_q    <= bus_wdata[PINS-1:0];
      if (wr[RI_ANALOG]) analog_q  <= bus_wdata[PINS-1:0];
      if (wr[RI_ALT_LO]) alt_lo_q  <= bus_wdata;
      if (wr[RI_ALT_HI]) alt_hi_q  <= bus_wdata;
    end
  end

  gpio_out_latch #(.PINS(PINS)) u_out (
    .clk(clk), .rst_n(rst_n),
    .wr_direct(wr[RI_OUT]), .wr_setclr(wr[RI_SETCLR]), .wr_clr(wr[RI_CLR]),
    .wdata(bus_wdata), .level(out_level)
  );

  always_comb begin
    words             = '0;
    words[RI_MODE]    = mode_cfg;
    words[RI_OTYPE]   = {{PINS{1'b0}}, otype_cfg};
    words[RI_SLEW]    = slew_cfg;
    words[RI_PULL]    = pull_cfg;
    words[RI_PIN_IN]  = {{PINS{1'b0}}, pin_level};
    words[RI_OUT]     = {{PINS{1'b0}}, out_level};
    words[RI_LOCK]    = {{PINS{1'b0}}, lock_q};
    words[RI_ALT_LO]  = alt_lo_q;
    words[RI_ALT_HI]  = alt_hi_q;
    words[RI_ANALOG]  = {{PINS{1'b0}}, analog_q};
  end

  gpio_read_mux #(.W(W), .N(NREGS)) u_rmux (
    .sel(sel), .words(words), .rd(rd_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata      <= '0;
      bus_err        <= 1'b0;
      contention_stb <= 1'b0;
      resolve_stb    <= 1'b0;
    end else begin
      if (bus_re) bus_rdata <= rd_nxt;
      bus_err        <= (bus_re | bus_we) & ~hit;
      contention_stb <= wr[RI_MODE] | wr[RI_OTYPE];
      resolve_stb    <= wr[RI_PULL] | wr[RI_OUT] | wr[RI_SETCLR] | wr[RI_CLR];
    end
  end

  AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && (sel[RI_SETCLR] || sel[RI_CLR]) |=> (bus_rdata == '0)); // R5
  AST_HALF_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && (sel[RI_OTYPE] || sel[RI_OUT] || sel[RI_LOCK] || sel[RI_ANALOG])
    |=> (bus_rdata[W-1:PINS] == '0)); // R7
  AST_MISS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re || bus_we) && !hit |=> bus_err); // R8
  AST_MISS_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && !hit |=> (bus_rdata == '0)); // R8
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && sel[RI_MODE]) |=> $stable(mode_cfg)); // R2
  AST_CONTENTION_STB: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && (sel[RI_MODE] || sel[RI_OTYPE]) |=> contention_stb); // R9
  AST_RESOLVE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && (sel[RI_PULL] || sel[RI_OUT] || sel[RI_SETCLR] || sel[RI_CLR])
    |=> resolve_stb); // R10
  AST_IDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && sel[RI_PIN_IN] |=> !resolve_stb && !contention_stb); // R6
endmodule

// File: tb/gpio_port_regs_test.sv
module gpio_port_regs_test;
  localparam int unsigned PINS = 16;
  localparam int unsigned AW   = 10;
  localparam logic [31:0] MODE_RST = 32'hABFF_0000;
  localparam logic [31:0] SLEW_RST = 32'h0C00_0000;
  localparam logic [31:0] PULL_RST = 32'h6410_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [15:0] pin_level = '0;
  logic [31:0] mode_cfg, slew_cfg, pull_cfg;
  logic [15:0] otype_cfg, out_level;
  logic        contention_stb, resolve_stb;

  always #4 clk = ~clk;

  gpio_port_regs #(.PINS(PINS), .AW(AW), .MODE_RST(MODE_RST),
                   .SLEW_RST(SLEW_RST), .PULL_RST(PULL_RST)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .pin_level(pin_level), .mode_cfg(mode_cfg),
    .otype_cfg(otype_cfg), .slew_cfg(slew_cfg), .pull_cfg(pull_cfg),
    .out_level(out_level), .contention_stb(contention_stb),
    .resolve_stb(resolve_stb)
  );

  // {write, addr, data (write data or expected read), pins, requirement}
  localparam int NV = 32;
  localparam logic [62:0] VEC [NV] = '{
    {1'b0, 10'h000, 32'hABFF_0000, 16'h0, 4'd1},  // R1
    {1'b0, 10'h008, 32'h0C00_0000, 16'h0, 4'd1},
    {1'b0, 10'h00C, 32'h6410_0000, 16'h0, 4'd1},
    {1'b0, 10'h014, 32'h0000_0000, 16'h0, 4'd1},
    {1'b1, 10'h014, 32'hFFFF_00F0, 16'h0, 4'd7},  // R7
    {1'b0, 10'h014, 32'h0000_00F0, 16'h0, 4'd7},
    {1'b1, 10'h018, 32'h0003_0101, 16'h0, 4'd3},  // R3 set wins on pin 0
    {1'b0, 10'h014, 32'h0000_01F1, 16'h0, 4'd3},
    {1'b1, 10'h018, 32'h00F0_0000, 16'h0, 4'd3},
    {1'b0, 10'h014, 32'h0000_0101, 16'h0, 4'd3},
    {1'b1, 10'h028, 32'hFFFF_0100, 16'h0, 4'd4},  // R4
    {1'b0, 10'h014, 32'h0000_0001, 16'h0, 4'd4},
    {1'b0, 10'h018, 32'h0000_0000, 16'h0, 4'd5},  // R5
    {1'b0, 10'h028, 32'h0000_0000, 16'h0, 4'd5},
    {1'b1, 10'h004, 32'hFFFF_1234, 16'h0, 4'd7},
    {1'b0, 10'h004, 32'h0000_1234, 16'h0, 4'd7},
    {1'b1, 10'h01C, 32'hFFFF_8001, 16'h0, 4'd7},
    {1'b0, 10'h01C, 32'h0000_8001, 16'h0, 4'd7},
    {1'b1, 10'h02C, 32'hABCD_0F0F, 16'h0, 4'd7},
    {1'b0, 10'h02C, 32'h0000_0F0F, 16'h0, 4'd7},
    {1'b1, 10'h020, 32'hDEAD_BEEF, 16'h0, 4'd2},  // R2
    {1'b0, 10'h020, 32'hDEAD_BEEF, 16'h0, 4'd2},
    {1'b1, 10'h024, 32'h1234_5678, 16'h0, 4'd2},
    {1'b0, 10'h024, 32'h1234_5678, 16'h0, 4'd2},
    {1'b1, 10'h008, 32'h5555_AAAA, 16'h0, 4'd2},
    {1'b0, 10'h008, 32'h5555_AAAA, 16'h0, 4'd2},
    {1'b0, 10'h010, 32'h0000_A5C3, 16'hA5C3, 4'd6}, // R6
    {1'b1, 10'h010, 32'hFFFF_FFFF, 16'hA5C3, 4'd6},
    {1'b0, 10'h010, 32'h0000_0F0F, 16'h0F0F, 4'd6},
    {1'b1, 10'h030, 32'hFFFF_FFFF, 16'h0, 4'd8},  // R8
    {1'b0, 10'h030, 32'h0000_0000, 16'h0, 4'd8},
    {1'b0, 10'h000, 32'hABFF_0000, 16'h0, 4'd8}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the access edge.
  task automatic access(input logic w, input logic [AW-1:0] a,
                        input logic [31:0] d, input logic [15:0] p);
    bus_we = w; bus_re = ~w; bus_addr = a; bus_wdata = w ? d : 32'h0; pin_level = p;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mode_cfg reset", mode_cfg, MODE_RST);
    check("R1 out_level reset", {16'h0, out_level}, 32'h0);
    check("R1 strobes/err reset", {29'h0, contention_stb, resolve_stb, bus_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][62], VEC[i][61:52], VEC[i][51:20], VEC[i][19:4]);
      if (!VEC[i][62]) begin
        n_chk++;
        if (bus_rdata !== VEC[i][51:20]) begin
          n_bad++;
          $display("FAIL R%0d vector %0d: actual %h expected %h",
                   VEC[i][3:0], i, bus_rdata, VEC[i][51:20]);
        end
      end
    end

    // R9 / R2 / R11: mode write, strobe and outputs one edge later
    access(1'b1, 10'h000, 32'h1111_2222, 16'h0);
    check("R9 contention_stb after mode write", {31'h0, contention_stb}, 32'h1);
    check("R10 resolve_stb idle on mode write", {31'h0, resolve_stb}, 32'h0);
    check("R11 mode_cfg follows write", mode_cfg, 32'h1111_2222);
    check("R11 slew_cfg holds", slew_cfg, 32'h5555_AAAA);
    check("R11 otype_cfg holds", {16'h0, otype_cfg}, 32'h1234);
    @(negedge clk);
    check("R9 contention_stb one cycle", {31'h0, contention_stb}, 32'h0);
    // R10 pull and set/clear writes
    access(1'b1, 10'h00C, 32'h0000_5555, 16'h0);
    check("R10 resolve_stb after pull write", {31'h0, resolve_stb}, 32'h1);
    check("R9 contention idle on pull write", {31'h0, contention_stb}, 32'h0);
    check("R11 pull_cfg", pull_cfg, 32'h0000_5555);
    access(1'b1, 10'h018, 32'h0001_0000, 16'h0);
    check("R10 resolve_stb after set/clear", {31'h0, resolve_stb}, 32'h1);
    check("R3 out_level cleared", {16'h0, out_level}, 32'h0);
    @(negedge clk);
    check("R10 resolve_stb one cycle", {31'h0, resolve_stb}, 32'h0);
    // R8 misaligned write and far unmapped read
    access(1'b1, 10'h002, 32'h0, 16'h0);
    check("R8 bus_err misaligned", {31'h0, bus_err}, 32'h1);
    check("R8 mode unchanged", mode_cfg, 32'h1111_2222);
    access(1'b0, 10'h3FC, 32'h0, 16'h0);
    check("R8 bus_err unmapped read", {31'h0, bus_err}, 32'h1);
    check("R8 unmapped read zero", bus_rdata, 32'h0);
    // R12 read latency and clean error flag
    access(1'b0, 10'h000, 32'h0, 16'h0);
    check("R12 read data next cycle", bus_rdata, 32'h1111_2222);
    check("R8 no error on mapped read", {31'h0, bus_err}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule